// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of 16-byte transmit descriptors kept in host memory. Each descriptor holds a control word at byte offset 0, a tag word at offset 4 that this engine does not use, the low half of the buffer address at offset 8 and the high half at offset 12. Software fills a descriptor, sets its ownership bit and rings a doorbell. The engine fetches the descriptor, asks a frame sender to transmit the buffer, writes the control word back with ownership cleared, and pulses an interrupt-status bit.

The engine keeps a single current-descriptor pointer. It moves on by 16 bytes after every write-back, or returns to the ring base when the finished descriptor carries the end-of-ring mark. When it reads a descriptor that software still holds, it stops and reports that no descriptor was available. The pointer is kept until the next doorbell. Only one descriptor is in flight at a time, and the memory port and the sender are never busy together.

Top module: `tdr_engine`

## Requirements
- R1: After reset, `mem_req`, `frm_req` and `int_evt` are low, and the first doorbell fetches the descriptor at byte address 0.
- R2: A write with `reg_sel`=1 and `reg_wdata` bit 6 set starts processing. The same write with bit 6 clear has no effect.
- R3: For an owned descriptor the engine reads the control word (offset 0), then the buffer low word (offset 8), then the buffer high word (offset 12). It then holds `frm_req` with `frm_addr`={high,low} and `frm_len`=control[15:0] stable until `frm_done`. `mem_addr` and `mem_we` stay stable while `mem_req` waits for `mem_ack`.
- R4: Only a descriptor with control bit 29 (first) and bit 28 (last) both set is sent. An owned descriptor missing either bit is not sent and ends with a transmit-error event.
- R5: Every owned descriptor is finished by exactly one write of its control word to offset 0, with bit 31 cleared and all other bits unchanged. For a sent frame this write follows `frm_done`.
- R6: `int_evt` gives one-cycle pulses with at most one bit high: bit 2 after the write-back of a frame completed with `frm_err` low, and bit 3 after the write-back of a frame reported with `frm_err` high or of a malformed descriptor.
- R7: When the control word read has bit 31 clear, the engine writes nothing, pulses `int_evt` bit 7 and goes idle.
- R8: After a write-back the pointer moves to the next 16-byte slot. If the control word has bit 30 set, it moves to the ring base instead.
- R9: The pointer persists across doorbells. A write with `reg_sel`=0 while idle sets the ring base from `reg_wdata` with bits 3:0 forced to zero and moves the pointer there. Such a write while the engine is active is ignored.
- R10: A doorbell that arrives while the engine is active is remembered. At the next unowned descriptor the engine reads that control word once more before it reports the event of R7.
- R11: `mem_req` and `frm_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects ring base, 1 selects doorbell |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write-back control word |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| frm_req | output | 1 | Frame send request, held until done |
| frm_addr | output | 64 | Buffer address of the frame |
| frm_len | output | 16 | Frame length in bytes |
| frm_done | input | 1 | Sender finished the frame (one-cycle pulse) |
| frm_err | input | 1 | Sender failure, valid with `frm_done` |
| int_evt | output | 16 | Interrupt-status pulses (bits 2, 3, 7) |

## Verification
The assertions assume that `mem_ack` only rises while `mem_req` is high and lasts one cycle per request. They also assume that `frm_done` only pulses while `frm_req` is high. The bench memory model answers a request one cycle after it appears and drops the acknowledge in the following cycle. The bench sender gives one done pulse after a fixed delay, so both assumptions hold by construction of the stimulus. Register writes are one-cycle strobes made at the falling edge, including the doorbells and base writes that are placed on purpose while a frame is in flight.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  // control-word bit positions
  localparam int OWN_BIT  = 31;
  localparam int EOR_BIT  = 30;
  localparam int FS_BIT   = 29;
  localparam int LS_BIT   = 28;
  localparam int LEN_W    = 16;

  // interrupt-status bit positions
  localparam int EVT_W    = 16;
  localparam int EVT_TOK  = 2;
  localparam int EVT_TER  = 3;
  localparam int EVT_TDU  = 7;

  // doorbell bit for the normal ring
  localparam int POLL_BIT = 6;

  // descriptor geometry (bytes)
  localparam int DESC_BYTES = 16;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_LO     = 8;
  localparam int OFS_HI     = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTRL,
    S_RD_LO,
    S_RD_HI,
    S_SEND,
    S_WB
  } tdr_state_e;

  function automatic logic owned(input logic [31:0] ctrl);
    return ctrl[OWN_BIT];
  endfunction

  function automatic logic whole_frame(input logic [31:0] ctrl);
    return ctrl[FS_BIT] & ctrl[LS_BIT];
  endfunction

  function automatic logic [31:0] wb_ctrl(input logic [31:0] ctrl);
    logic [31:0] w;
    w = ctrl;
    w[OWN_BIT] = 1'b0;
    return w;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [31:0] ctrl);
    return ctrl[LEN_W-1:0];
  endfunction

endpackage

// File: rtl/tdr_regs.sv
module tdr_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              active,
  output logic [ADDR_W-1:0] base_q,
  output logic              base_load,
  output logic [ADDR_W-1:0] base_new,
  output logic              kick
);
  import tdr_pkg::*;

  localparam int ALIGN_BITS = $clog2(DESC_BYTES);

  function automatic logic [ADDR_W-1:0] align_base(input logic [31:0] w);
    logic [ADDR_W-1:0] a;
    a = w[ADDR_W-1:0];
    a[ALIGN_BITS-1:0] = '0;
    return a;
  endfunction

  assign base_new  = align_base(reg_wdata);
  assign base_load = reg_we && (reg_sel == 1'b0) && !active;
  assign kick      = reg_we && (reg_sel == 1'b1) && reg_wdata[POLL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_load) base_q <= base_new;
  end

  // R9: base register frozen while engine is busy
  p_base_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(base_q));

endmodule

// File: rtl/tdr_ptr.sv
module tdr_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  import tdr_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  function automatic logic [ADDR_W-1:0] next_slot(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] rb,
    input logic              at_end);
    return at_end ? rb : cur + STEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_addr <= '0;
    else if (load)    cur_addr <= load_addr;
    else if (advance) cur_addr <= next_slot(cur_addr, base, wrap);
  end

  // R8: end-of-ring returns to base
  p_wrap_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !load) |=> (cur_addr == $past(base)));

  // R8: otherwise step one slot
  p_step_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load) |=> (cur_addr == $past(cur_addr) + STEP));

  // R9: pointer holds between events
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(cur_addr));

endmodule

// File: rtl/tdr_fsm.sv
module tdr_fsm #(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      kick,
  input  logic [ADDR_W-1:0]         cur_addr,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_ack,
  input  logic [31:0]               mem_rdata,
  output logic                      frm_req,
  output logic [63:0]               frm_addr,
  output logic [tdr_pkg::LEN_W-1:0] frm_len,
  input  logic                      frm_done,
  input  logic                      frm_err,
  output logic                      advance,
  output logic                      wrap,
  output logic                      active,
  output logic [tdr_pkg::EVT_W-1:0] evt
);
  import tdr_pkg::*;

  tdr_state_e         state_q, state_d;
  logic [31:0]        ctrl_q, ctrl_d;
  logic [31:0]        lo_q, lo_d;
  logic [31:0]        hi_q, hi_d;
  logic               err_q, err_d;
  logic               pend_q, pend_d;
  logic [EVT_W-1:0]   evt_q, evt_d;

  function automatic logic [ADDR_W-1:0] word_addr(
    input logic [ADDR_W-1:0] cur, input tdr_state_e st);
    case (st)
      S_RD_LO: return cur + ADDR_W'(OFS_LO);
      S_RD_HI: return cur + ADDR_W'(OFS_HI);
      default: return cur + ADDR_W'(OFS_CTRL);
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    err_d   = err_q;
    pend_d  = pend_q | (kick && (state_q != S_IDLE));
    evt_d   = '0;
    advance = 1'b0;
    case (state_q)
      S_IDLE: begin
        pend_d = 1'b0;
        if (kick) state_d = S_RD_CTRL;
      end
      S_RD_CTRL: if (mem_ack) begin
        ctrl_d = mem_rdata;
        if (!owned(mem_rdata)) begin
          pend_d = 1'b0;
          if (!(pend_q || kick)) begin
            state_d        = S_IDLE;
            evt_d[EVT_TDU] = 1'b1;
          end
        end else if (whole_frame(mem_rdata)) begin
          state_d = S_RD_LO;
        end else begin
          err_d   = 1'b1;
          state_d = S_WB;
        end
      end
      S_RD_LO: if (mem_ack) begin
        lo_d    = mem_rdata;
        state_d = S_RD_HI;
      end
      S_RD_HI: if (mem_ack) begin
        hi_d    = mem_rdata;
        err_d   = 1'b0;
        state_d = S_SEND;
      end
      S_SEND: if (frm_done) begin
        err_d   = frm_err;
        state_d = S_WB;
      end
      S_WB: if (mem_ack) begin
        advance = 1'b1;
        if (err_q) evt_d[EVT_TER] = 1'b1;
        else       evt_d[EVT_TOK] = 1'b1;
        state_d = S_RD_CTRL;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      evt_q   <= '0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      evt_q   <= evt_d;
    end
  end

  assign mem_req   = (state_q == S_RD_CTRL) || (state_q == S_RD_LO) ||
                     (state_q == S_RD_HI)   || (state_q == S_WB);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = word_addr(cur_addr, state_q);
  assign mem_wdata = wb_ctrl(ctrl_q);
  assign frm_req   = (state_q == S_SEND);
  assign frm_addr  = {hi_q, lo_q};
  assign frm_len   = frame_len(ctrl_q);
  assign wrap      = ctrl_q[EOR_BIT];
  assign active    = (state_q != S_IDLE);
  assign evt       = evt_q;

  // R11: memory and sender never busy together
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && frm_req));

  // R6: at most one status bit per cycle
  p_evt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));

  // R3: memory request held stable until acknowledged
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: frame request held stable until done
  p_frm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_req && !frm_done) |=> (frm_req && $stable(frm_addr) && $stable(frm_len)));

  // R5: write-back always hands ownership back
  p_wb_own_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  // R7: unavailable event leaves the engine quiet
  p_tdu_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt[EVT_TDU] |-> (!mem_req && !frm_req));

  // R5: write-back only follows a completed send or malformed fetch
  p_wb_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_req && frm_done) |=> (mem_req && mem_we));

endmodule

// File: rtl/tdr_engine.sv
module tdr_engine #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              frm_req,
  output logic [63:0]       frm_addr,
  output logic [15:0]       frm_len,
  input  logic              frm_done,
  input  logic              frm_err,
  output logic [15:0]       int_evt
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_new;
  logic [ADDR_W-1:0] cur_addr;
  logic              base_load;
  logic              kick;
  logic              active;
  logic              advance;
  logic              wrap;

  tdr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .active    (active),
    .base_q    (base_q),
    .base_load (base_load),
    .base_new  (base_new),
    .kick      (kick)
  );

  tdr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (base_load),
    .load_addr (base_new),
    .base      (base_q),
    .advance   (advance),
    .wrap      (wrap),
    .cur_addr  (cur_addr)
  );

  tdr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .cur_addr  (cur_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .frm_req   (frm_req),
    .frm_addr  (frm_addr),
    .frm_len   (frm_len),
    .frm_done  (frm_done),
    .frm_err   (frm_err),
    .advance   (advance),
    .wrap      (wrap),
    .active    (active),
    .evt       (int_evt)
  );

endmodule

// File: tb/tb_tdr_engine.sv
module tb_tdr_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        frm_req;
  logic [63:0] frm_addr;
  logic [15:0] frm_len;
  logic        frm_done = 1'b0;
  logic        frm_err = 1'b0;
  logic [15:0] int_evt;

  always #10 clk = ~clk;

  tdr_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .frm_req(frm_req), .frm_addr(frm_addr),
    .frm_len(frm_len), .frm_done(frm_done), .frm_err(frm_err),
    .int_evt(int_evt)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // memory model: 32 words = 8 descriptor slots
  logic [31:0] mem [32];
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[6:2]];
      if (mem_we) mem[mem_addr[6:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // sender model
  localparam int SEND_DLY = 3;
  logic        sender_err = 1'b0;
  int          dly = 0;
  int          n_frames = 0;
  logic [63:0] last_addr = '0;
  logic [15:0] last_len = '0;
  always @(posedge clk) begin
    if (frm_req && !frm_done) begin
      if (dly == SEND_DLY) begin
        frm_done  <= 1'b1;
        frm_err   <= sender_err;
        dly       <= 0;
        n_frames  <= n_frames + 1;
        last_addr <= frm_addr;
        last_len  <= frm_len;
      end else begin
        dly <= dly + 1;
      end
    end else begin
      frm_done <= 1'b0;
    end
  end

  // port monitor
  int n_tok = 0, n_ter = 0, n_tdu = 0, n_wr = 0, n_overlap = 0, n_multi = 0;
  int rd_cnt [8];
  initial for (int i = 0; i < 8; i++) rd_cnt[i] = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (int_evt[2]) n_tok <= n_tok + 1;
      if (int_evt[3]) n_ter <= n_ter + 1;
      if (int_evt[7]) n_tdu <= n_tdu + 1;
      if ($countones(int_evt) > 1) n_multi <= n_multi + 1;
      if (mem_req && frm_req) n_overlap <= n_overlap + 1;
      if (mem_req && mem_ack && mem_we) n_wr <= n_wr + 1;
      if (mem_req && mem_ack && !mem_we && mem_addr[3:0] == 4'h0)
        rd_cnt[mem_addr[6:4]] <= rd_cnt[mem_addr[6:4]] + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_tdu(input int target);
    for (int k = 0; k < 300 && n_tdu < target; k++) @(negedge clk);
    chk("R7 wait for unavailable event", 64'(n_tdu), 64'(target));
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_frm;
    for (int k = 0; k < 60 && !frm_req; k++) @(negedge clk);
  endtask

  // vector: {ctrl[31:0], send, sender_err, tok}
  localparam logic [34:0] VEC [6] = '{
    {32'hB000_0040, 1'b1, 1'b0, 1'b1},
    {32'hB000_05DC, 1'b1, 1'b1, 1'b0},
    {32'hA000_0100, 1'b0, 1'b0, 1'b0},
    {32'hF000_003C, 1'b1, 1'b0, 1'b1},
    {32'hB000_FFFF, 1'b1, 1'b0, 1'b1},
    {32'h9000_0020, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int f0, t0, e0, d0, w0, r0, r7;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    // trap descriptor at slot 4 (must not be reached by the ring walk)
    mem[16] = 32'hB000_0777; mem[18] = 32'h4444_0000; mem[19] = 32'h0000_0044;

    repeat (3) @(negedge clk);
    chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
    chk("R1 frm_req after reset", 64'(frm_req), 64'd0);
    chk("R1 int_evt after reset", 64'(int_evt), 64'd0);

    // table walk: ring of slots 0..3, slot 3 marks end of ring
    for (int i = 0; i < 6; i++) begin
      int slot;
      logic [34:0] v;
      logic [31:0] ctrl;
      slot = i % 4;
      v = VEC[i];
      ctrl = v[34:3];
      @(negedge clk);
      mem[slot*4]   = ctrl;
      mem[slot*4+1] = '0;
      mem[slot*4+2] = 32'h1000_0000 + 32'(i * 16);
      mem[slot*4+3] = 32'h0000_00A0 + 32'(i);
      sender_err = v[1];
      f0 = n_frames; t0 = n_tok; e0 = n_ter; d0 = n_tdu; w0 = n_wr;
      write_reg(1'b1, 32'h0000_0040);
      wait_tdu(d0 + 1);
      chk($sformatf("R4 frame sent vec%0d", i), 64'(n_frames - f0), 64'(v[2]));
      chk($sformatf("R6 tok pulses vec%0d", i), 64'(n_tok - t0), 64'(v[0]));
      chk($sformatf("R6 ter pulses vec%0d", i), 64'(n_ter - e0), 64'(!v[0]));
      chk($sformatf("R5 write-back word vec%0d", i), 64'(mem[slot*4]), 64'(ctrl & 32'h7FFF_FFFF));
      chk($sformatf("R7 single write vec%0d", i), 64'(n_wr - w0), 64'd1);
      if (v[2]) begin
        chk($sformatf("R3 frame addr vec%0d", i), last_addr,
            {32'h0000_00A0 + 32'(i), 32'h1000_0000 + 32'(i * 16)});
        chk($sformatf("R3 frame len vec%0d", i), 64'(last_len), 64'(ctrl[15:0]));
      end
      if (i == 0) chk("R1 first fetch at address 0", 64'(rd_cnt[0]), 64'd1);
    end
    chk("R8 wrap skips slot past end", 64'(rd_cnt[4]), 64'd0);

    // R2: doorbell without bit 6 ignored (pointer at slot 2)
    @(negedge clk);
    mem[8] = 32'hB000_0080; mem[10] = 32'h2222_0000; mem[11] = '0;
    sender_err = 1'b0;
    r0 = rd_cnt[2]; f0 = n_frames; d0 = n_tdu;
    write_reg(1'b1, 32'h0000_00BF);
    repeat (20) @(negedge clk);
    chk("R2 no fetch without bit 6", 64'(rd_cnt[2] - r0), 64'd0);
    chk("R2 no frame without bit 6", 64'(n_frames - f0), 64'd0);
    write_reg(1'b1, 32'h0000_0040);
    wait_tdu(d0 + 1);
    chk("R2 doorbell sends frame len", 64'(last_len), 64'h80);

    // R9: base write while idle, low bits ignored -> slot 4
    d0 = n_tdu;
    write_reg(1'b0, 32'h0000_0047);
    write_reg(1'b1, 32'h0000_0040);
    wait_tdu(d0 + 1);
    chk("R9 fetch at new base", 64'(rd_cnt[4]), 64'd1);
    chk("R9 frame from new base len", 64'(last_len), 64'h777);
    chk("R9 frame from new base addr", last_addr, 64'h0000_0044_4444_0000);

    // R9: base write while active ignored (pointer at slot 5)
    @(negedge clk);
    mem[20] = 32'hB000_0055; mem[22] = 32'h5555_0000; mem[23] = '0;
    d0 = n_tdu; r0 = rd_cnt[0];
    write_reg(1'b1, 32'h0000_0040);
    wait_frm();
    write_reg(1'b0, 32'h0000_0000);
    wait_tdu(d0 + 1);
    chk("R9 base write while active ignored", 64'(rd_cnt[6]), 64'd1);
    chk("R9 no fetch at written base", 64'(rd_cnt[0] - r0), 64'd0);

    // R10: doorbell while active causes one extra control read (pointer at slot 6)
    @(negedge clk);
    mem[24] = 32'hB000_0066; mem[26] = 32'h6666_0000; mem[27] = '0;
    d0 = n_tdu; r7 = rd_cnt[7];
    write_reg(1'b1, 32'h0000_0040);
    wait_frm();
    write_reg(1'b1, 32'h0000_0040);
    wait_tdu(d0 + 1);
    repeat (10) @(negedge clk);
    chk("R10 remembered doorbell rereads", 64'(rd_cnt[7] - r7), 64'd2);
    chk("R10 single unavailable event", 64'(n_tdu - d0), 64'd1);

    chk("R11 memory and sender overlap", 64'(n_overlap), 64'd0);
    chk("R6 multiple event bits", 64'(n_multi), 64'd0);
    report();
  end

endmodule